// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Compare Event

This block is a memory-mapped timer for a processor subsystem. It keeps a 64-bit up-counter that advances by one on each clock in which a count-tick input is high and counting is switched on. Software reads and writes the counter as two 32-bit words. A 64-bit compare value sits beside it. When comparison is enabled and the count is at or beyond the compare value, a sticky event flag is raised.

An optional step register lets the compare value move itself forward by a programmed amount on every event. This gives periodic events without software stepping in. Without the step, the comparator fires once per crossing and must be re-armed. A single level interrupt output follows the event flag, gated by two control bits.

The register bus is minimal: a byte address, a write strobe, write data and combinational read data. The word offsets are 0x00 count low, 0x04 count high, 0x08 control, 0x0C status, 0x10 compare low, 0x14 compare high and 0x18 step. Any other offset reads as zero.

Top module: `gtmr_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With control bit 0 set, the count rises by one at each clock edge where `tick` is high. With bit 0 clear, or `tick` low, the count holds. The count wraps from all ones to zero.
- R3: The two count halves are read at 0x00 and 0x04 without any latching. A carry from the low half into the high half shows up between two reads of the high half.
- R4: A write to a count half loads that half from the bus and cancels any increment in that cycle. The other half keeps its value.
- R5: While control bit 1 is set and the comparator is armed, status bit 0 is set at the edge after the count first becomes greater than or equal to the compare value. This includes the case where the count is already above the compare value.
- R6: Without auto-step, one crossing raises the flag only once. It stays clear after a clear while the count remains at or above the compare value. Writing either compare half, or setting control bit 1 from 0, arms the comparator again.
- R7: With control bit 3 set, each event adds the 32-bit step value (0x18, zero-extended) to the 64-bit compare value at the same edge that sets the flag.
- R8: While control bit 1 is clear, writing the compare halves never sets the flag.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If an event and a clear fall on the same edge, the flag ends set.
- R10: `irq` is high exactly when the flag, control bit 2 and control bit 1 are all set.
- R11: Control (4 bits), compare halves and step read back as written, and offsets outside the map read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one increment per high cycle |
| bus_addr | input | 5 | Byte address of the word accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
Two kinds of collision are provoked on purpose. The first is a status clear that lands on the same edge as a new compare event: the bench lets the count reach the compare value and issues the clear write in exactly that cycle, then expects the flag to stay set and the compare value to have advanced by the step. The second is a write to a count half while `tick` is high: the read-back must equal the written word with no increment added. Random runs from a fixed seed load random counts and thresholds and compare both count halves and the flag against values computed in the bench.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_STEP   = 5'h18;

    // packed: step_on is bit 3, run is bit 0
    typedef struct packed {
        logic step_on;
        logic irq_on;
        logic cmp_on;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic ctrl;
        logic stat;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
    } wsel_t;

    function automatic wsel_t decode_write(input logic [ADDR_W-1:0] a, input logic we);
        wsel_t s;
        s.cnt_lo = we && (a == OFS_CNT_LO);
        s.cnt_hi = we && (a == OFS_CNT_HI);
        s.ctrl   = we && (a == OFS_CTRL);
        s.stat   = we && (a == OFS_STAT);
        s.cmp_lo = we && (a == OFS_CMP_LO);
        s.cmp_hi = we && (a == OFS_CMP_HI);
        s.step   = we && (a == OFS_STEP);
        return s;
    endfunction

endpackage

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                run,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] count
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] count_q;
    logic             any_wr;

    assign any_wr = wr_lo || wr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (any_wr) begin
            if (wr_lo) count_q[HALF_W-1:0]     <= wdata;
            if (wr_hi) count_q[CNT_W-1:HALF_W] <= wdata;
        end else if (run && tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R2: one step per enabled tick, wrapping naturally
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !any_wr) |=> (count == $past(count) + 1'b1));

    // R2: idle counter holds its value
    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!(run && tick) && !any_wr) |=> $stable(count));

    // R4: written low half wins, upper half untouched
    p_write_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (count[HALF_W-1:0] == $past(wdata))
                           && (count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W])));
endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*HALF_W-1:0] count,
    input  logic                cmp_on,
    input  logic                cmp_rearm,
    input  logic                step_on,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                wr_step,
    input  logic                clr_req,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] cmp_val,
    output logic [HALF_W-1:0]   step_val,
    output logic                flag
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0]  cmp_q;
    logic [HALF_W-1:0] step_q;
    logic              armed_q;
    logic              flag_q;
    logic              hit;
    logic              cmp_wr;

    assign cmp_wr = wr_lo || wr_hi;
    assign hit    = cmp_on && armed_q && (count >= cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            if (wr_lo) cmp_q[HALF_W-1:0]     <= wdata;
            if (wr_hi) cmp_q[CNT_W-1:HALF_W] <= wdata;
        end else if (hit && step_on) begin
            cmp_q <= cmp_q + {{HALF_W{1'b0}}, step_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          step_q <= '0;
        else if (wr_step) step_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                     armed_q <= 1'b0;
        else if (cmp_wr || cmp_rearm) armed_q <= 1'b1;
        else if (hit && !step_on)    armed_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign cmp_val  = cmp_q;
    assign step_val = step_q;
    assign flag     = flag_q;

    // R7: auto-step advances compare by the step on an event
    p_step_adv_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && step_on && !cmp_wr) |=> (cmp_val == $past(cmp_val) + {{HALF_W{1'b0}}, $past(step_val)}));

    // R8: with comparison off a clear flag cannot become set
    p_off_no_set_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmp_on && !flag) |=> !flag);

    // R9: event beats a concurrent clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);

    // R9: a clear without an event empties the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> !flag);

    // R6: single-shot mode disarms after its event
    p_one_shot_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && !step_on && !cmp_wr && !cmp_rearm) |=> !hit);
endmodule

// File: rtl/gtmr_timer.sv
module gtmr_timer
    import gtmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int CTRL_W = $bits(ctrl_t);

    wsel_t              sel;
    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   cmp_val;
    logic [DATA_W-1:0]  step_val;
    logic               flag;
    logic               rearm;
    logic               clr_req;

    assign sel     = decode_write(bus_addr, bus_we);
    assign rearm   = sel.ctrl && bus_wdata[1] && !ctrl_q.cmp_on;
    assign clr_req = sel.stat && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst)           ctrl_q <= '0;
        else if (sel.ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    gtmr_counter #(.HALF_W(DATA_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .run   (ctrl_q.run),
        .wr_lo (sel.cnt_lo),
        .wr_hi (sel.cnt_hi),
        .wdata (bus_wdata),
        .count (count)
    );

    gtmr_compare #(.HALF_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .count     (count),
        .cmp_on    (ctrl_q.cmp_on),
        .cmp_rearm (rearm),
        .step_on   (ctrl_q.step_on),
        .wr_lo     (sel.cmp_lo),
        .wr_hi     (sel.cmp_hi),
        .wr_step   (sel.step),
        .clr_req   (clr_req),
        .wdata     (bus_wdata),
        .cmp_val   (cmp_val),
        .step_val  (step_val),
        .flag      (flag)
    );

    always_comb begin
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = count[DATA_W-1:0];
            OFS_CNT_HI: bus_rdata = count[CNT_W-1:DATA_W];
            OFS_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_STAT:   bus_rdata = {{(DATA_W-1){1'b0}}, flag};
            OFS_CMP_LO: bus_rdata = cmp_val[DATA_W-1:0];
            OFS_CMP_HI: bus_rdata = cmp_val[CNT_W-1:DATA_W];
            OFS_STEP:   bus_rdata = step_val;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = flag && ctrl_q.irq_on && ctrl_q.cmp_on;

    // R10: interrupt drops once comparison is switched off
    p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
        (sel.ctrl && !bus_wdata[1]) |=> !irq);

    // R11: control register reflects the last write
    p_ctrl_wr_r11: assert property (@(posedge clk) disable iff (rst)
        sel.ctrl |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));
endmodule

// File: tb/gtmr_timer_test.sv
module gtmr_timer_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    gtmr_timer uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    function automatic logic [63:0] add64(input logic [63:0] a, input logic [63:0] b);
        return a + b;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic tk = 1'b0);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d; tick = tk;
        @(posedge clk);
        #1 we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d, hi0;
        logic [63:0] start, thr;
        int seed, n, k;
        seed = $urandom(32'd4242);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), d);
            chk("R1 reg", d, 0);
        end
        chk("R1 irq", irq, 0);

        // R2: counting, hold, wrap
        wr(5'h08, 32'h1);
        rd(5'h08, d); chk("R11 ctrl", d, 1);
        ticks(5);
        rd(5'h00, d); chk("R2 count", d, 5);
        wr(5'h08, 32'h0);
        ticks(3);
        rd(5'h00, d); chk("R2 hold", d, 5);
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h08, 32'h1);
        ticks(1);
        rd(5'h00, d); chk("R2 wrap lo", d, 0);
        rd(5'h04, d); chk("R2 wrap hi", d, 0);

        // R3: carry visible between high reads
        wr(5'h08, 32'h0);
        wr(5'h00, 32'hFFFF_FFFE);
        wr(5'h04, 32'h7);
        wr(5'h08, 32'h1);
        rd(5'h04, hi0); chk("R3 first hi", hi0, 7);
        ticks(2);
        rd(5'h00, d); chk("R3 lo", d, 0);
        rd(5'h04, d); chk("R3 second hi", d, 8);

        // R4: write during a tick wins, no increment
        wr(5'h00, 32'h100, 1'b1);
        rd(5'h00, d); chk("R4 lo", d, 32'h100);
        rd(5'h04, d); chk("R4 hi kept", d, 8);

        // R8: compare write while comparison off
        wr(5'h10, 32'h50);
        wr(5'h14, 32'h8);
        idle(2);
        rd(5'h0C, d); chk("R8 no flag", d, 0);

        // R5: enabling with count already above
        wr(5'h08, 32'h3);
        idle(1);
        rd(5'h0C, d); chk("R5 above", d, 1);
        chk("R10 irq masked", irq, 0);
        wr(5'h08, 32'h7);
        rd(5'h0C, d); chk("R10 irq high", irq, 1);

        // R6 / R9: clear, no re-fire while above
        wr(5'h0C, 32'h1);
        idle(3);
        rd(5'h0C, d); chk("R6 no refire", d, 0);
        chk("R10 irq low", irq, 0);
        wr(5'h10, 32'h50);
        idle(1);
        rd(5'h0C, d); chk("R6 rearm by write", d, 1);
        wr(5'h0C, 32'h0);
        rd(5'h0C, d); chk("R9 write zero", d, 1);
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R9 clear", d, 0);

        // R5: crossing by exact equality
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h10);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'h14);
        wr(5'h14, 32'h0);
        wr(5'h0C, 32'h1);
        wr(5'h08, 32'h3);
        ticks(3);
        rd(5'h0C, d); chk("R5 below", d, 0);
        ticks(1);
        idle(1);
        rd(5'h0C, d); chk("R5 equal", d, 1);

        // R7: auto-step
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h1);
        wr(5'h00, 32'h0);
        wr(5'h10, 32'd10);
        wr(5'h18, 32'd10);
        wr(5'h08, 32'hB);
        rd(5'h18, d); chk("R11 step", d, 10);
        rd(5'h08, d); chk("R11 ctrl bits", d, 32'hB);
        ticks(10);
        idle(1);
        rd(5'h0C, d); chk("R7 flag", d, 1);
        rd(5'h10, d); chk("R7 cmp advanced", d, 20);
        idle(2);
        rd(5'h10, d); chk("R7 single advance", d, 20);

        // R9: event and clear on the same edge
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R9 pre clear", d, 0);
        ticks(10);
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R9 set wins", d, 1);
        rd(5'h10, d); chk("R7 cmp second", d, 30);

        // R11: unmapped offset
        rd(5'h1C, d); chk("R11 unmapped", d, 0);

        // R2 / R5: random counts and thresholds
        for (int it = 0; it < 24; it++) begin
            start = {($urandom() % 32'hFFFF_FF00), $urandom()};
            n = int'($urandom() % 40) + 1;
            k = int'($urandom() % 41);
            thr = add64(start, 64'(k));
            wr(5'h08, 32'h0);
            wr(5'h00, start[31:0]);
            wr(5'h04, start[63:32]);
            wr(5'h10, thr[31:0]);
            wr(5'h14, thr[63:32]);
            wr(5'h0C, 32'h1);
            wr(5'h08, 32'h3);
            ticks(n);
            idle(1);
            rd(5'h00, d); chk("R2 rand lo", d, add64(start, 64'(n)) & 64'hFFFF_FFFF);
            rd(5'h04, d); chk("R2 rand hi", d, add64(start, 64'(n)) >> 32);
            rd(5'h0C, d); chk("R5 rand flag", d, (n >= k) ? 1 : 0);
        end

        summary();
        $finish;
    end
endmodule